// File: doc/BRIEF.md
# Fractional-N Programmable Clock Divider

This block divides a stream of fast input pulses down to one output pulse per division cycle. The fast clock is represented as a one-clock-wide enable pulse, `tick_in`, inside a single synchronous clock domain. The block is set up with an integer ratio and an 8-bit fraction. Each division cycle lasts either N or N+1 input pulses. A first-order sigma-delta accumulator decides the length of each cycle, so that over time the average ratio comes to N plus the fraction divided by 256.

The ratio and fraction are written with a `load` strobe. When the divider is idle, after reset, the first load starts it at once. When it is running, a load is held in a staging register and takes effect only at the next cycle boundary. This means no cycle ever mixes two ratios. The selection bit for each cycle is brought out so that a loop or a monitor can see which cycles were stretched.

Top module: `frac_div_top`

## Requirements
- R1: After a synchronous reset, `div_pulse` and `sel_plus1` are low. The divider stays idle, ignoring input pulses, until the first `load`.
- R2: With a zero fraction, every division cycle takes exactly N input pulses. `div_pulse` is high from the (L-1)th pulse of a cycle of length L until its Lth pulse (the terminal pulse), which is one input-pulse period.
- R3: Every cycle has length N or N+1. `sel_plus1` is high during a cycle of length N+1 and low during a cycle of length N, and it changes only at a cycle boundary.
- R4: An 8-bit accumulator adds the fraction at each terminal pulse. Its carry-out selects N+1 for the following cycle. The first cycle after a start divides by N, with the accumulator cleared.
- R5: Over any 256 consecutive cycles with a constant fraction p, exactly p cycles have length N+1.
- R6: A load while running is applied at the next terminal pulse. If several loads come before that pulse, the last one wins. A load on the same clock as a terminal pulse is applied at that boundary.
- R7: A ratio below 2 is clamped to 2.
- R8: The counter advances only on clocks where `tick_in` is high. Gaps between input pulses change neither the outputs nor the cycle length measured in pulses.
- R9: Changes to `ratio_int` or `ratio_frac` without `load` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Input pulse (one fast-clock edge) |
| load | input | 1 | Captures ratio and fraction; starts an idle divider |
| ratio_int | input | 8 | Integer ratio N (values below 2 become 2) |
| ratio_frac | input | 8 | Fraction p, in units of 1/256 |
| div_pulse | output | 1 | Divided output, high during the last input period of each cycle |
| sel_plus1 | output | 1 | High when the current cycle lasts N+1 pulses |

## Verification
The divider is first run with back-to-back input pulses and a zero fraction, which isolates the integer count. It is then run with pulses gapped by a pseudo-random pattern, which separates counting clocks from counting pulses. Fractions of 64 and 255 are each held for a full 256-cycle window, and the number of stretched cycles and the total pulse count are compared against the exact expected values; these runs expose accumulator width or carry errors. Loads are placed mid-cycle, back to back, and exactly on a terminal pulse, which pins down when staged values are taken. Ratios of 0 and 1 exercise the clamp.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int DEF_INT_W  = 8;
  localparam int DEF_FRAC_W = 8;
  localparam int MIN_RATIO  = 2;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ON   = 1'b1
  } run_e;
endpackage

// File: rtl/frac_div_shadow.sv
module frac_div_shadow #(
  parameter int INT_W  = frac_div_pkg::DEF_INT_W,
  parameter int FRAC_W = frac_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adopt,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic [INT_W-1:0]  act_n,
  output logic [FRAC_W-1:0] take_p
);
  function automatic logic [INT_W-1:0] clamp_ratio(input logic [INT_W-1:0] v);
    return (v < INT_W'(frac_div_pkg::MIN_RATIO)) ? INT_W'(frac_div_pkg::MIN_RATIO) : v;
  endfunction

  logic [INT_W-1:0]  stage_n;
  logic [FRAC_W-1:0] stage_p;
  logic [FRAC_W-1:0] act_p;
  logic              pend;
  logic [INT_W-1:0]  in_n;
  logic [INT_W-1:0]  take_n;

  always_comb begin
    in_n   = clamp_ratio(ratio_int);
    take_n = load ? in_n       : (pend ? stage_n : act_n);
    take_p = load ? ratio_frac : (pend ? stage_p : act_p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_n <= INT_W'(frac_div_pkg::MIN_RATIO);
      stage_p <= '0;
      act_n   <= INT_W'(frac_div_pkg::MIN_RATIO);
      act_p   <= '0;
      pend    <= 1'b0;
    end else if (adopt) begin
      act_n <= take_n;
      act_p <= take_p;
      pend  <= 1'b0;
    end else if (load) begin
      stage_n <= in_n;
      stage_p <= ratio_frac;
      pend    <= 1'b1;
    end
  end
endmodule

// File: rtl/frac_div_sdm.sv
module frac_div_sdm #(
  parameter int FRAC_W = frac_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              boundary,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              sel
);
  function automatic logic [FRAC_W:0] acc_add(input logic [FRAC_W-1:0] a,
                                              input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  always_comb sum = acc_add(acc, frac_in);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      acc <= '0;
      sel <= 1'b0;
    end else if (boundary) begin
      acc <= sum[FRAC_W-1:0];
      sel <= sum[FRAC_W];
    end
  end
endmodule

// File: rtl/frac_div_cnt.sv
module frac_div_cnt #(
  parameter int INT_W = frac_div_pkg::DEF_INT_W,
  localparam int CNT_W = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             running,
  input  logic             tick,
  input  logic [CNT_W-1:0] cycle_len,
  output logic             last,
  output logic             boundary
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    last     = running && (cnt == cycle_len - CNT_W'(1));
    boundary = tick && last;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (running && tick) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/frac_div_top.sv
module frac_div_top #(
  parameter int INT_W  = frac_div_pkg::DEF_INT_W,
  parameter int FRAC_W = frac_div_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              load,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic              div_pulse,
  output logic              sel_plus1
);
  localparam int CNT_W = INT_W + 1;

  function automatic logic [CNT_W-1:0] len_of(input logic [INT_W-1:0] n, input logic s);
    return {1'b0, n} + {{INT_W{1'b0}}, s};
  endfunction

  frac_div_pkg::run_e run_q;
  logic               running;
  logic               start;
  logic               boundary;
  logic               last;
  logic               sel;
  logic [INT_W-1:0]   act_n;
  logic [FRAC_W-1:0]  take_p;
  logic [CNT_W-1:0]   cycle_len;

  always_comb begin
    running   = (run_q == frac_div_pkg::RUN_ON);
    start     = load && !running;
    cycle_len = len_of(act_n, sel);
  end

  always_ff @(posedge clk) begin
    if (rst)       run_q <= frac_div_pkg::RUN_IDLE;
    else if (load) run_q <= frac_div_pkg::RUN_ON;
  end

  frac_div_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) shadow_i (
    .clk(clk), .rst(rst), .load(load), .adopt(boundary || start),
    .ratio_int(ratio_int), .ratio_frac(ratio_frac),
    .act_n(act_n), .take_p(take_p)
  );

  frac_div_sdm #(.FRAC_W(FRAC_W)) sdm_i (
    .clk(clk), .rst(rst), .start(start), .boundary(boundary),
    .frac_in(take_p), .sel(sel)
  );

  frac_div_cnt #(.INT_W(INT_W)) cnt_i (
    .clk(clk), .rst(rst), .start(start), .running(running), .tick(tick_in),
    .cycle_len(cycle_len), .last(last), .boundary(boundary)
  );

  assign div_pulse = last;
  assign sel_plus1 = sel;
endmodule

// File: rtl/frac_div_chk.sv
module frac_div_chk #(
  parameter int INT_W = frac_div_pkg::DEF_INT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_in,
  input logic             div_pulse,
  input logic             sel_plus1,
  input logic             run_w,
  input logic [INT_W-1:0] act_n_w
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_w |-> (!div_pulse && !sel_plus1)); // R1
  AST_PULSE_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (tick_in && div_pulse) |=> !div_pulse); // R2
  AST_SEL_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (run_w && !(tick_in && div_pulse)) |=> $stable(sel_plus1)); // R3
  AST_FIRST_CYCLE_N: assert property (@(posedge clk) disable iff (rst)
    $rose(run_w) |-> !sel_plus1); // R4
  AST_RATIO_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    run_w |-> (act_n_w >= INT_W'(2))); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> ($stable(div_pulse) && $stable(sel_plus1))); // R8
endmodule

bind frac_div_top frac_div_chk #(.INT_W(INT_W)) chk_i (
  .clk(clk), .rst(rst), .tick_in(tick_in), .div_pulse(div_pulse),
  .sel_plus1(sel_plus1), .run_w(running), .act_n_w(act_n)
);

// File: tb/frac_div_top_tb_top.sv
module frac_div_top_tb_top;
  logic       clk = 1'b0;
  logic       rst, tick_in, load;
  logic [7:0] ratio_int, ratio_frac;
  wire        div_pulse, sel_plus1;

  always #5 clk = ~clk;

  frac_div_top dut_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .load(load),
    .ratio_int(ratio_int), .ratio_frac(ratio_frac),
    .div_pulse(div_pulse), .sel_plus1(sel_plus1)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  // reference model state
  bit m_run, m_sel, m_pend;
  int m_n, m_p, m_cnt, m_acc, m_stn, m_stp;
  // observation bookkeeping
  int ticks_since, last_iv, term_cnt, sel_cnt, ticks_total;
  int cur_ni, cur_pf;
  logic [7:0] lf = 8'h5A;

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_sel = 0; m_pend = 0; m_n = 2; m_p = 0;
    m_cnt = 0; m_acc = 0; m_stn = 2; m_stp = 0;
  endtask

  task automatic step(bit tk, bit ld, int ni, int pf);
    int cn, nn, np, s;
    bit exp_div, term;
    @(negedge clk);
    exp_div = m_run && (m_cnt == m_n + m_sel - 1);
    chk_eq("R2", "div_pulse", int'(div_pulse), int'(exp_div));
    chk_eq("R3", "sel_plus1", int'(sel_plus1), m_run ? int'(m_sel) : 0);
    term = m_run && tk && exp_div;
    if (m_run && tk) ticks_total++;
    if (term) begin
      last_iv = ticks_since + 1; ticks_since = 0;
      term_cnt++; sel_cnt += int'(m_sel);
    end else if (m_run && tk) ticks_since++;
    tick_in = tk; load = ld; ratio_int = ni[7:0]; ratio_frac = pf[7:0];
    cur_ni = ni; cur_pf = pf;
    cn = (ni < 2) ? 2 : ni;
    if (!m_run) begin
      if (ld) begin
        m_run = 1; m_n = cn; m_p = pf; m_cnt = 0; m_acc = 0; m_sel = 0; m_pend = 0;
        ticks_since = 0;
      end
    end else if (term) begin
      nn = ld ? cn : (m_pend ? m_stn : m_n);
      np = ld ? pf : (m_pend ? m_stp : m_p);
      s = m_acc + np;
      m_sel = (s >= 256); m_acc = s % 256;
      m_n = nn; m_p = np; m_pend = 0; m_cnt = 0;
    end else begin
      if (tk) m_cnt++;
      if (ld) begin m_stn = cn; m_stp = pf; m_pend = 1; end
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1; tick_in = 0; load = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic run_terms(int k);
    int target;
    target = term_cnt + k;
    while (term_cnt < target) step(1, 0, cur_ni, cur_pf);
  endtask

  task automatic frac_window(int n, int p);
    int t0;
    step(1, 1, n, p);
    run_terms(1);                       // adoption boundary
    sel_cnt = 0; t0 = ticks_total;
    run_terms(256);
    chk_eq("R5", "stretched cycles in 256", sel_cnt, p);
    chk_eq("R5", "pulses in 256 cycles", ticks_total - t0, 256 * n + p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; tick_in = 0; load = 0; ratio_int = 0; ratio_frac = 0;
    cur_ni = 0; cur_pf = 0;
    ticks_since = 0; last_iv = 0; term_cnt = 0; sel_cnt = 0; ticks_total = 0;
    reset_dut();
    @(negedge clk);
    chk_eq("R1", "div_pulse after reset", int'(div_pulse), 0);
    chk_eq("R1", "sel_plus1 after reset", int'(sel_plus1), 0);
    for (int i = 0; i < 12; i++) step(1, 0, 5, 0);   // R1: idle ignores ticks
    step(0, 0, 5, 0);
    chk_eq("R1", "idle div_pulse", int'(div_pulse), 0);

    // R2: integer division, back-to-back pulses
    step(0, 1, 5, 0);
    run_terms(6);
    chk_eq("R2", "interval N=5", last_iv, 5);

    // R8: gapped pulses
    for (int i = 0; i < 200; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[0] ^ lf[2], 0, 5, 0);
    end
    run_terms(1);
    chk_eq("R8", "interval with gaps", last_iv, 5);

    // R9: inputs change without load
    cur_ni = 9; cur_pf = 77;
    run_terms(4);
    chk_eq("R9", "interval unchanged", last_iv, 5);

    // R6: two loads mid-cycle, last wins
    step(1, 1, 7, 0);
    step(1, 1, 3, 0);
    run_terms(3);
    chk_eq("R6", "last load wins", last_iv, 3);
    // R6: load on the terminal pulse
    while (!(m_cnt == m_n + m_sel - 1)) step(1, 0, 3, 0);
    step(1, 1, 6, 0);
    run_terms(1);
    chk_eq("R6", "load at boundary", last_iv, 6);

    // R7: clamp
    step(1, 1, 0, 0);
    run_terms(3);
    chk_eq("R7", "ratio 0 clamped", last_iv, 2);
    step(1, 1, 1, 0);
    run_terms(3);
    chk_eq("R7", "ratio 1 clamped", last_iv, 2);

    // R5: fractional windows
    frac_window(3, 64);
    frac_window(2, 255);

    // R4: restart after reset, first cycle N, carry order
    reset_dut();
    step(0, 1, 4, 200);
    run_terms(1);
    chk_eq("R4", "first cycle length", last_iv, 4);
    run_terms(1);
    chk_eq("R4", "second cycle length", last_iv, 4);
    run_terms(1);
    chk_eq("R4", "third cycle length", last_iv, 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule